// File: doc/BRIEF.md
# Triangle-Wave Numerically Controlled Oscillator with Reduced-Rate Mode

This block is a phase-accumulator oscillator that drives a 7-bit unsigned code into an external resistor-ladder converter. The converter output then serves as the reference for a downstream phase-locked loop. The accumulator advances once per sample strobe. A divide-by-13 prescaler produces that strobe from the system clock: a 12 MHz clock gives about 923 kHz. A tuning word sets the phase increment. With a 25-bit accumulator, an increment of 568 moves the output by roughly 15.6 Hz, and an increment of 36352 moves it by about 1 kHz. The usable output band is roughly 47 kHz to 234 kHz.

The upper bits of the phase are folded into a triangle rather than looked up in a sine table. In reduced-rate mode only every eighth prescaler tick becomes a sample strobe, and the applied increment is the tuning word shifted left by three. The output frequency therefore stays the same. While this mode is in force, the block raises a hold-off flag so that the loop's charge pump can be frozen.

The tuning word and the mode input are both taken only at a sample strobe. The increment applied at a strobe covers the interval up to the next strobe, and the length of that interval is set by the mode captured at the same strobe.

Top module: `tri_nco`

## Requirements
- R1: During and after synchronous reset (rstN low), waveOut is 0 and pllDisable is 0. The first sample strobe occurs on the 13th rising edge after reset is released.
- R2: In normal mode (pllDisable low), sample strobes are exactly 13 clocks apart. waveOut changes only in the cycle that follows a strobe.
- R3: At each strobe in normal mode, the 25-bit phase advances by tuneWord modulo 2^25.
- R4: When pllDisable is high, strobes are exactly 104 clocks (8 x 13) apart. Each such strobe advances the phase by tuneWord x 8 modulo 2^25.
- R5: pllDisable changes only in the cycle after a strobe, and then takes the value that slowMode had at that strobe.
- R6: Changes on tuneWord or slowMode between strobes have no effect on waveOut or pllDisable until the next strobe.
- R7: waveOut equals phase bits [23:17] when phase bit 24 is 0, and the bitwise inverse of those bits when bit 24 is 1. The result is a triangle from 0 up to 127 and back.
- R8: The phase wraps modulo 2^25 without saturation, including with large increments in reduced-rate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| tuneWord | input | 25 | Phase increment per normal-rate sample |
| slowMode | input | 1 | Request for the one-eighth sample rate |
| waveOut | output | 7 | Folded triangle code for the ladder converter |
| pllDisable | output | 1 | High while the reduced rate is in force |

## Verification
On every cycle the assertions check the spacing between strobes for the current mode, the stability of waveOut and pllDisable between strobes, and that pllDisable tracks the mode captured at the previous strobe. They also check that the output is quiet during reset.

Only the bench scenarios can show the numerical results: the phase sums taken modulo 2^25, the times-eight scaling of the increment, the fold at the half-period, and wrap-around with large words. The bench compares every cycle against a model it computes arithmetically. That model runs across sweeps of tuning words, mode switches in the middle of an interval, and tuning-word changes between strobes.

// File: rtl/tri_nco_pkg.sv
package tri_nco_pkg;
  typedef struct packed {
    logic sample;    // advance phase and capture inputs this cycle
    logic slowNext;  // mode that will apply for the coming interval
  } ncoStrobes_t;
endpackage

// File: rtl/tri_nco_ctrl.sv
module tri_nco_ctrl
  import tri_nco_pkg::*;
#(
  parameter int PRESCALE   = 13,
  parameter int SLOW_SHIFT = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        slowMode,
  output ncoStrobes_t strb,
  output logic        slowActive
);
  localparam int PRE_W  = $clog2(PRESCALE);
  localparam int SLOW_W = (SLOW_SHIFT > 0) ? SLOW_SHIFT : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [SLOW_W-1:0] slowCnt;
  logic              tick;
  logic              slowGate;

  assign tick = (preCnt == PRE_LAST);

  generate
    if (SLOW_SHIFT > 0) begin : g_gate
      assign slowGate = &slowCnt;
    end else begin : g_nogate
      assign slowGate = 1'b1;
    end
  endgenerate

  always_comb begin
    strb.sample   = tick && (!slowActive || slowGate);
    strb.slowNext = slowMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt     <= '0;
      slowCnt    <= '0;
      slowActive <= 1'b0;
    end else begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick) slowCnt <= slowActive ? slowCnt + 1'b1 : '0;
      if (strb.sample) slowActive <= strb.slowNext;
    end
  end
endmodule

// File: rtl/tri_nco_datapath.sv
module tri_nco_datapath
  import tri_nco_pkg::*;
#(
  parameter int ACC_W      = 25,
  parameter int OUT_W      = 7,
  parameter int SLOW_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ncoStrobes_t      strb,
  input  logic [ACC_W-1:0] tuneWord,
  output logic [OUT_W-1:0] waveOut
);
  localparam int FOLD_LSB = ACC_W - 1 - OUT_W;

  logic [ACC_W-1:0] phase;
  logic [ACC_W-1:0] step;
  logic [OUT_W-1:0] rawBits;

  assign step    = strb.slowNext ? (tuneWord << SLOW_SHIFT) : tuneWord;
  assign rawBits = phase[ACC_W-2 -: OUT_W];
  assign waveOut = phase[ACC_W-1] ? ~rawBits : rawBits;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= '0;
    else if (strb.sample) phase <= phase + step;
  end

  if (FOLD_LSB < 0) begin : g_bad
    initial $error("ACC_W too small for OUT_W");
  end
endmodule

// File: rtl/tri_nco.sv
module tri_nco
  import tri_nco_pkg::*;
#(
  parameter int ACC_W      = 25,
  parameter int OUT_W      = 7,
  parameter int PRESCALE   = 13,
  parameter int SLOW_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [ACC_W-1:0] tuneWord,
  input  logic             slowMode,
  output logic [OUT_W-1:0] waveOut,
  output logic             pllDisable
);
  ncoStrobes_t strb;

  tri_nco_ctrl #(.PRESCALE(PRESCALE), .SLOW_SHIFT(SLOW_SHIFT)) u_ctrl (
    .clk(clk), .rstN(rstN), .slowMode(slowMode),
    .strb(strb), .slowActive(pllDisable)
  );

  tri_nco_datapath #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SLOW_SHIFT(SLOW_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .tuneWord(tuneWord), .waveOut(waveOut)
  );
endmodule

// File: rtl/tri_nco_checker.sv
module tri_nco_checker #(
  parameter int OUT_W      = 7,
  parameter int PRESCALE   = 13,
  parameter int SLOW_SHIFT = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             sample,
  input logic             slowMode,
  input logic [OUT_W-1:0] waveOut,
  input logic             pllDisable
);
  localparam int SLOW_GAP = PRESCALE * (1 << SLOW_SHIFT);
  localparam int GAP_W    = $clog2(SLOW_GAP + 1);

  logic [GAP_W-1:0] gap;
  always_ff @(posedge clk) begin
    if (!rstN || sample) gap <= '0;
    else gap <= gap + 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (waveOut == '0 && !pllDisable));

  a_r2_normal_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (sample && !pllDisable) |-> (gap == GAP_W'(PRESCALE - 1)));

  a_r4_slow_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (sample && pllDisable) |-> (gap == GAP_W'(SLOW_GAP - 1)));

  a_r2_no_early_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (gap < GAP_W'(PRESCALE - 1)) |-> !sample);

  a_r6_wave_stable: assert property (@(posedge clk) disable iff (!rstN)
    !sample |=> $stable(waveOut));

  a_r5_flag_stable: assert property (@(posedge clk) disable iff (!rstN)
    !sample |=> $stable(pllDisable));

  a_r5_flag_follows: assert property (@(posedge clk) disable iff (!rstN)
    sample |=> (pllDisable == $past(slowMode)));
endmodule

bind tri_nco tri_nco_checker #(
  .OUT_W(OUT_W), .PRESCALE(PRESCALE), .SLOW_SHIFT(SLOW_SHIFT)
) u_chk (
  .clk(clk), .rstN(rstN), .sample(strb.sample), .slowMode(slowMode),
  .waveOut(waveOut), .pllDisable(pllDisable)
);

// File: tb/tri_nco_tb.sv
module tri_nco_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W = 25;
  localparam int OUT_W = 7;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [ACC_W-1:0] tuneWord = '0;
  logic             slowMode = 1'b0;
  logic [OUT_W-1:0] waveOut;
  logic             pllDisable;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  tri_nco u_dut (.clk(clk), .rstN(rstN), .tuneWord(tuneWord),
                 .slowMode(slowMode), .waveOut(waveOut), .pllDisable(pllDisable));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model built from the requirements
  int               mPre;
  int               mSlowCnt;
  logic             mSlow;
  logic [ACC_W-1:0] mAcc;

  always @(posedge clk) begin
    if (!rstN) begin
      mPre <= 0; mSlowCnt <= 0; mSlow <= 1'b0; mAcc <= '0;
    end else begin
      bit tk, smp;
      tk  = (mPre == 12);
      smp = tk && (!mSlow || mSlowCnt == 7);
      mPre <= tk ? 0 : mPre + 1;
      if (tk) mSlowCnt <= mSlow ? (mSlowCnt + 1) % 8 : 0;
      if (smp) begin
        mAcc  <= mAcc + (slowMode ? ACC_W'(tuneWord * 8) : tuneWord);
        mSlow <= slowMode;
      end
    end
  end

  function automatic logic [OUT_W-1:0] fold(input logic [ACC_W-1:0] p);
    logic [OUT_W-1:0] b;
    b = p[23:17];
    return p[24] ? ~b : b;
  endfunction

  task automatic check(input string tag);
    nTests++;
    if (waveOut !== fold(mAcc) || pllDisable !== mSlow) begin
      nFail++;
      $display("FAIL %s: wave=%0d flag=%0b expected wave=%0d flag=%0b",
               tag, waveOut, pllDisable, fold(mAcc), mSlow);
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    nTests++;
    if (waveOut !== '0 || pllDisable !== 1'b0) begin
      nFail++;
      $display("FAIL R1: wave=%0d flag=%0b expected wave=0 flag=0", waveOut, pllDisable);
    end
    rstN = 1'b1;
    // R1: no strobe in the first 12 edges even with a large word
    tuneWord = 25'd4000000;
    run(12, "R1");
    run(1, "R1");
    // R2/R3: sweep of tuning words in normal mode, 1 kHz step pattern
    for (int k = 0; k < 16; k++) begin
      tuneWord = ACC_W'(568 + k * 36352 * 15);
      run(13 * 9, "R3");
    end
    // R7: full triangle period with a word that visits every code
    tuneWord = 25'd131072;
    run(13 * 260, "R7");
    // R6: word changed mid-interval has no effect until the strobe
    for (int k = 0; k < 10; k++) begin
      tuneWord = ACC_W'(1000 * k + 7);
      run(5, "R6");
      tuneWord = ACC_W'(8500000 - k);
      run(8, "R6");
    end
    // R4/R5: enter slow mode and sweep words
    slowMode = 1'b1;
    for (int k = 0; k < 6; k++) begin
      tuneWord = ACC_W'(1409024 + k * 1400000);
      run(104 * 4, "R4");
    end
    // R6: mode pulses between strobes are ignored
    for (int k = 0; k < 5; k++) begin
      slowMode = 1'b0; run(30, "R6");
      slowMode = 1'b1; run(40, "R6");
    end
    // R5: leave slow mode mid-interval
    slowMode = 1'b0;
    run(104 * 2, "R5");
    // R8: wrap with largest words in both modes
    tuneWord = '1;
    run(13 * 20, "R8");
    slowMode = 1'b1;
    run(104 * 6, "R8");
    // R5: toggle mode repeatedly at varied offsets
    for (int k = 0; k < 8; k++) begin
      slowMode = ~slowMode;
      tuneWord = ACC_W'(36352 * (k + 40));
      run(50 + 17 * k, "R5");
    end
    // R1: reset mid-run returns outputs to idle
    rstN = 1'b0;
    run(3, "R1");
    rstN = 1'b1;
    slowMode = 1'b0;
    run(13 * 4, "R2");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule